// File: doc/BRIEF.md
# Event Counter Bank with Overflow Flags

This block counts hardware events. Each of its event inputs feeds a dedicated counter. The counter advances by one on every clock cycle in which its input is high, as long as counting is globally switched on and that input is not suppressed. Software reaches the bank through a simple word-addressed register port. It can switch counting on and off, suppress individual inputs, read any counter and read a packed word of overflow flags. Reads return data one cycle after the request.

When a counter at its maximum value advances, it wraps to zero and latches a flag in the overflow word. These flags are sticky. They clear only on reset, or when software writes the control register with its clear bit set. A single level interrupt output is high while any flag is set. Counters can never be loaded from the bus, so a reading always reflects events that were actually counted since the last reset.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every mapped register (control 0x00, counters, overflow word 0x44, suppress mask 0x48) reads zero, and `ovf_irq` is low.
- R2: Counter i is at byte offset 0x04+4*i. It increases by exactly one at each clock edge where `evt_i[i]` is high, control bit 0 is 1 and suppress bit i is 0. Counters are independent of each other.
- R3: While control bit 0 (run) is 0, no counter changes. Only bit 0 of the control register is stored, so writing 0xFFFFFFFF to it reads back as 0x00000001.
- R4: Bus writes to counter offsets have no effect. A counter written with all ones keeps its counted value.
- R5: A counter holding all ones (0xFFFFFFFF at the default width) that advances becomes zero, and bit i of the overflow word (0x44) becomes 1 at the same edge. With all sixteen counters wrapped, the overflow word reads 0x0000FFFF.
- R6: `ovf_irq` is high in the cycle after any overflow bit is set, and stays high exactly while at least one overflow bit is 1.
- R7: Overflow bits are sticky. A control write with bit 1 set clears them all, and bit 1 itself is never stored. If a wrap happens at the same edge as the clear, that counter's bit ends up set.
- R8: Bit i of the suppress mask at 0x48 stops counter i from counting. The mask resets to all zeros.
- R9: A read request on `bus_rd_en` yields `bus_rvalid` high and `bus_rdata` holding the register value at the request edge, one cycle later. Unmapped or non-word-aligned offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Event inputs, one per counter |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ovf_irq | output | 1 | High while any overflow flag is set |

## Verification
The counting function is driven with single-input, alternating, half-bank and full-bank event masks, each held for a different number of cycles. This shows whether counters are independent and whether the count per cycle is exact. The same table varies the run bit and the suppress mask, which separates the global gate from the per-input gate. Directed sequences take counters to exactly one below wrap and then one past it. They confirm that the flag and interrupt appear only on the wrapping edge, that flags persist and clear on command, and that a wrap coinciding with a clear still leaves its flag set.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
   // control register bit positions
   localparam int RUN_BIT = 0;
   localparam int CLR_BIT = 1;
   // word index of the control register
   localparam int CTRL_WIDX = 0;

   // word index of counter n
   function automatic int cnt_widx(input int n);
      return n + 1;
   endfunction

   // word index of overflow word, then suppress mask
   function automatic int ovf_widx(input int n_evt);
      return n_evt + 1;
   endfunction

   function automatic int sup_widx(input int n_evt);
      return n_evt + 2;
   endfunction
endpackage

// File: rtl/evt_ctr_cell.sv
module evt_ctr_cell #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;
   assign wrap  = inc & (&cnt_q);

   // R2: exact increment of one
   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !(&count)) |=> (count == $past(count) + 1'b1));
   // R3/R8: no change without an increment request
   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
   // R5: wrap lands on zero
   assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));
endmodule

// File: rtl/evt_ovf_flags.sv
module evt_ovf_flags #(
   parameter int NUM_EVT = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic               clr_i,
   output logic [NUM_EVT-1:0] flags,
   output logic               irq
);
   logic [NUM_EVT-1:0] flags_q, flags_d;

   // a wrap at the clearing edge wins over the clear
   assign flags_d = (clr_i ? '0 : flags_q) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags = flags_q;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |flags_d;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |flags_q;
      end
   endgenerate

   // R6: any new wrap raises the interrupt next cycle
   assert_irq_on_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> irq);
   // R7: flags are sticky without a clear
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((flags & $past(flags)) == $past(flags)));
   // R7: a clear with no wrap empties the word
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (flags == '0 && !irq));
endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
   import evt_ctr_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_EVT*CNT_W-1:0] cnt_flat,
   input  logic [NUM_EVT-1:0]       ovf_flags,
   output logic                     run,
   output logic [NUM_EVT-1:0]       suppress,
   output logic                     clr_pulse,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rvalid
);
   localparam int IDXW = ADDR_W - 2;

   logic [IDXW-1:0]   widx;
   logic              aligned;
   logic              wr_ok;
   logic [DATA_W-1:0] rd_mux;

   assign widx      = addr[ADDR_W-1:2];
   assign aligned   = (addr[1:0] == 2'b00);
   assign wr_ok     = wr_en & aligned;
   assign clr_pulse = wr_ok && (widx == IDXW'(CTRL_WIDX)) && wdata[CLR_BIT];

   always_comb begin
      rd_mux = '0;
      if (aligned) begin
         if (widx == IDXW'(CTRL_WIDX)) rd_mux[RUN_BIT] = run;
         if (widx == IDXW'(ovf_widx(NUM_EVT))) rd_mux[NUM_EVT-1:0] = ovf_flags;
         if (widx == IDXW'(sup_widx(NUM_EVT))) rd_mux[NUM_EVT-1:0] = suppress;
         for (int i = 0; i < NUM_EVT; i++) begin
            if (widx == IDXW'(cnt_widx(i))) rd_mux[CNT_W-1:0] = cnt_flat[i*CNT_W +: CNT_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         suppress <= '0;
         rdata    <= '0;
         rvalid   <= 1'b0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= rd_mux;
         if (wr_ok && widx == IDXW'(CTRL_WIDX)) run <= wdata[RUN_BIT];
         if (wr_ok && widx == IDXW'(sup_widx(NUM_EVT))) suppress <= wdata[NUM_EVT-1:0];
      end
   end

   // R9: one-cycle read response
   assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);
   assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);
   // R3: run only moves on a control write
   assert_run_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && widx == IDXW'(CTRL_WIDX)) |=> $stable(run));
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
   import evt_ctr_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               bus_wr_en,
   input  logic               bus_rd_en,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_rvalid,
   output logic               ovf_irq
);
   localparam int IDXW = ADDR_W - 2;

   initial begin
      assert (NUM_EVT >= 1 && NUM_EVT <= DATA_W) else $error("NUM_EVT out of range");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert ((NUM_EVT + 3) * 4 <= (1 << ADDR_W)) else $error("ADDR_W too small for map");
   end

   logic                     run;
   logic                     clr_pulse;
   logic [NUM_EVT-1:0]       suppress;
   logic [NUM_EVT-1:0]       inc;
   logic [NUM_EVT-1:0]       wrap;
   logic [NUM_EVT-1:0]       ovf_flags;
   logic [NUM_EVT*CNT_W-1:0] cnt_flat;

   generate
      for (genvar g = 0; g < NUM_EVT; g++) begin : g_ctr
         assign inc[g] = run & evt_i[g] & ~suppress[g];

         evt_ctr_cell #(.CNT_W(CNT_W)) i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .count (cnt_flat[g*CNT_W +: CNT_W]),
            .wrap  (wrap[g])
         );

         // R4: a bus write to this counter never moves it
         assert_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr[ADDR_W-1:2] == IDXW'(cnt_widx(g)) && !inc[g])
            |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
         // R8: suppressed input never counts
         assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
            suppress[g] |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
      end
   endgenerate

   evt_ovf_flags #(.NUM_EVT(NUM_EVT), .IRQ_REG(IRQ_REG)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wrap),
      .clr_i (clr_pulse),
      .flags (ovf_flags),
      .irq   (ovf_irq)
   );

   evt_reg_if #(
      .NUM_EVT (NUM_EVT),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr_en),
      .rd_en     (bus_rd_en),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .cnt_flat  (cnt_flat),
      .ovf_flags (ovf_flags),
      .run       (run),
      .suppress  (suppress),
      .clr_pulse (clr_pulse),
      .rdata     (bus_rdata),
      .rvalid    (bus_rvalid)
   );

   // R3: with run low, nothing is counted
   assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (inc == '0));
   // R6: interrupt low while no flag is set
   assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flags == '0 && wrap == '0) |=> (IRQ_REG ? 1'b1 : !ovf_irq) || (ovf_flags != '0));
endmodule

// File: tb/test_evt_ctr_bank.sv
module test_evt_ctr_bank;
   localparam int NE  = 16;
   localparam int CW  = 8;
   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam int NV  = 8;

   // vector: {event mask[40:25], cycles[24:17], suppress mask[16:1], run[0]}
   localparam logic [40:0] VEC [NV] = '{
      {16'h0001, 8'd3,  16'h0000, 1'b1},
      {16'h8000, 8'd5,  16'h0000, 1'b1},
      {16'hA5A5, 8'd4,  16'h0000, 1'b1},
      {16'hFFFF, 8'd2,  16'h0000, 1'b1},
      {16'hFFFF, 8'd7,  16'h0000, 1'b0},
      {16'h00FF, 8'd6,  16'h000F, 1'b1},
      {16'h5A5A, 8'd1,  16'h0000, 1'b1},
      {16'hFFFF, 8'd10, 16'hFFFF, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [CW-1:0] model [NE];

   always #10 clk = ~clk;

   evt_ctr_bank #(.NUM_EVT(NE), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) i_evt_ctr_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
      .ovf_irq(irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NE; i++) model[i] = '0;
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check("R9 rvalid", {31'b0, rvalid}, 32'd1);
      d = rdata;
   endtask

   task automatic pulse_evt(input logic [NE-1:0] m, input int n);
      @(negedge clk);
      evt = m;
      repeat (n) @(negedge clk);
      evt = '0;
   endtask

   task automatic chk_counters(input string tag);
      logic [DW-1:0] d;
      for (int i = 0; i < NE; i++) begin
         bus_rd(AW'(4 + 4 * i), d);
         check(tag, d, {{(DW-CW){1'b0}}, model[i]});
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      do_reset();

      // R1: reset values
      check("R1 irq", {31'b0, irq}, 32'd0);
      for (int a = 0; a <= 18; a++) begin
         bus_rd(AW'(4 * a), d);
         check("R1 reset read", d, 32'd0);
      end
      @(negedge clk);
      check("R9 rvalid idle", {31'b0, rvalid}, 32'd0);
      bus_rd(8'h4C, d);
      check("R9 unmapped", d, 32'd0);
      bus_rd(8'h05, d);
      check("R9 unaligned", d, 32'd0);

      // R4: write all ones to counters right after reset
      for (int i = 0; i < NE; i++) bus_wr(AW'(4 + 4 * i), 32'hFFFF_FFFF);
      chk_counters("R4 write after reset");

      // R3: control readback keeps only run
      bus_wr(8'h00, 32'hFFFF_FFFF);
      bus_rd(8'h00, d);
      check("R3 ctrl readback", d, 32'h1);
      bus_wr(8'h00, 32'h0);

      // table of patterns: R2, R3, R8
      for (int v = 0; v < NV; v++) begin
         logic [15:0] m, s;
         logic [7:0]  c;
         logic        r;
         m = VEC[v][40:25]; c = VEC[v][24:17]; s = VEC[v][16:1]; r = VEC[v][0];
         bus_wr(8'h48, {16'b0, s});
         bus_wr(8'h00, {31'b0, r});
         pulse_evt(m, int'(c));
         for (int i = 0; i < NE; i++)
            if (r && m[i] && !s[i]) model[i] = model[i] + c;
         chk_counters("R2 R3 R8 table");
         bus_rd(8'h48, d);
         check("R8 mask readback", d, {16'b0, s});
         bus_rd(8'h44, d);
         check("R5 no overflow", d, 32'd0);
      end

      // R4: writes after counting leave values
      for (int i = 0; i < NE; i++) bus_wr(AW'(4 + 4 * i), 32'hFFFF_FFFF);
      chk_counters("R4 write after count");

      // R5/R6: single counter to the edge and past it
      do_reset();
      bus_wr(8'h00, 32'h1);
      pulse_evt(16'h0001, 255);
      bus_rd(8'h04, d);
      check("R5 at max", d, 32'h0000_00FF);
      bus_rd(8'h44, d);
      check("R5 no flag yet", d, 32'd0);
      check("R6 irq low", {31'b0, irq}, 32'd0);
      pulse_evt(16'h0001, 1);
      check("R6 irq high", {31'b0, irq}, 32'd1);
      bus_rd(8'h04, d);
      check("R5 wrapped", d, 32'd0);
      bus_rd(8'h44, d);
      check("R5 flag bit0", d, 32'h1);

      // R7: sticky, then clear
      pulse_evt(16'h0002, 3);
      bus_rd(8'h44, d);
      check("R7 sticky", d, 32'h1);
      check("R7 irq sticky", {31'b0, irq}, 32'd1);
      bus_wr(8'h00, 32'h3);
      check("R7 irq cleared", {31'b0, irq}, 32'd0);
      bus_rd(8'h44, d);
      check("R7 cleared", d, 32'd0);
      bus_rd(8'h00, d);
      check("R7 clear bit not stored", d, 32'h1);

      // R7: wrap and clear at the same edge
      pulse_evt(16'h0001, 255);
      @(negedge clk);
      evt = 16'h0001; wr_en = 1'b1; addr = 8'h00; wdata = 32'h3;
      @(negedge clk);
      evt = '0; wr_en = 1'b0;
      check("R7 set wins irq", {31'b0, irq}, 32'd1);
      bus_rd(8'h44, d);
      check("R7 set wins", d, 32'h1);
      bus_rd(8'h04, d);
      check("R5 wrap during clear", d, 32'd0);

      // R5: whole bank wraps
      do_reset();
      bus_wr(8'h00, 32'h1);
      pulse_evt(16'hFFFF, 256);
      bus_rd(8'h44, d);
      check("R5 all flags", d, 32'h0000_FFFF);
      check("R6 irq all", {31'b0, irq}, 32'd1);
      chk_counters("R5 all wrapped");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule